// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block walks a memory controller through the column addresses of one read or write burst. The controller loads a start column together with the burst length code and the order bit that its mode register holds. The block then presents the first column on the next cycle and moves to the following column each time the controller signals that a data beat has been transferred. It raises a last-beat flag on the final beat of a finite burst, so the controller knows when to issue its next command without keeping its own count.

Two orders are supported. Sequential order counts the low bits of the column upward and wraps them inside an aligned block of the burst length. Interleaved order flips the low start bits with the beat index. The full-page length has neither boundary nor end: it steps through every column of the row, returns to the start column after the whole row and carries on until the controller stops it with the terminate strobe. Loading a new start column at any time abandons the running burst and begins a fresh one.

Top module: `burst_col_gen`

## Requirements
- R1: After reset `valid_o` and `last_o` are 0 and `col_o` is 0.
- R2: One cycle after `load_i` is high, `valid_o` is 1 and `col_o` equals the `start_col_i` value given with the load, exactly.
- R3: Length code on `blen_i`: 0 gives 1 beat, 1 gives 2, 2 gives 4, 3 gives 8 and 7 gives full page; codes 4, 5 and 6 are treated as 1 beat.
- R4: With `ilv_i` = 0 and a finite length N, beat k presents the start column with its low log2(N) bits replaced by (start + k) mod N; the bits above them never change during the burst.
- R5: With `ilv_i` = 1 and a finite length N, beat k presents the start column with its low log2(N) bits XORed with k.
- R6: `last_o` is 1 exactly on beat N-1 of a finite burst; an advance on that beat ends the burst, so `valid_o` is 0 on the next cycle.
- R7: In full-page mode beat k presents (start + k) mod 2^COL_W, so beat 2^COL_W presents the start column again and the burst continues; `last_o` stays 0 and `ilv_i` has no effect.
- R8: `terminate_i` ends an active burst: `valid_o` and `last_o` are 0 on the next cycle. While idle it changes nothing.
- R9: A load during an active burst restarts from the new start column; a load wins over a terminate or an advance given in the same cycle.
- R10: While `valid_o` is 1 and none of the strobes is high, `col_o` and `valid_o` hold their values.
- R11: `advance_i` while idle leaves `valid_o` at 0 and `col_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Start a new burst |
| start_col_i | input | COL_W | Start column captured on load |
| blen_i | input | 3 | Burst length code captured on load |
| ilv_i | input | 1 | Order captured on load: 0 sequential, 1 interleaved |
| advance_i | input | 1 | Current beat transferred, move to the next |
| terminate_i | input | 1 | Stop the running burst |
| col_o | output | COL_W | Column of the current beat |
| valid_o | output | 1 | A burst is active and `col_o` is meaningful |
| last_o | output | 1 | Current beat is the final one of a finite burst |

## Verification
The hardest situation to reach is the wrap of a full-page burst, which only appears after every column of the row has been visited once. The stimulus loads a start column near the top of the row, with the interleave bit set so that ignoring it is checked too, and advances through more than a full row of beats, comparing each column and confirming the last-beat flag never rises, before terminating. Restart and priority cases are reached by loading while a burst is mid-way, in the same cycle as a terminate or an advance.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;

   localparam int LEN_CODE_W = 3;

   typedef enum logic [LEN_CODE_W-1:0] {
      LEN_ONE   = 3'd0,
      LEN_TWO   = 3'd1,
      LEN_FOUR  = 3'd2,
      LEN_EIGHT = 3'd3,
      LEN_ROW   = 3'd7
   } len_code_e;

endpackage

// File: rtl/bcg_len_decode.sv
module bcg_len_decode
   import burst_col_pkg::*;
#(
   parameter int COL_W = 8
) (
   input  logic [LEN_CODE_W-1:0] code_i,
   output logic [COL_W-1:0]      mask_o,
   output logic                  full_o
);

   initial begin
      if (COL_W < 3 || COL_W > 16)
         $error("bcg_len_decode: COL_W must lie in 3..16");
   end

   always_comb begin
      full_o = 1'b0;
      case (code_i)
         LEN_TWO:   mask_o = COL_W'(1);
         LEN_FOUR:  mask_o = COL_W'(3);
         LEN_EIGHT: mask_o = COL_W'(7);
         LEN_ROW: begin
            mask_o = '1;
            full_o = 1'b1;
         end
         default:   mask_o = '0;
      endcase
   end

endmodule

// File: rtl/bcg_beat_ctr.sv
module bcg_beat_ctr #(
   parameter int COL_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic             terminate_i,
   input  logic             advance_i,
   input  logic             full_i,
   input  logic [COL_W-1:0] len_mask_i,
   output logic [COL_W-1:0] beat_o,
   output logic             valid_o,
   output logic             last_o
);

   logic [COL_W-1:0] beat_q;
   logic             valid_q;

   assign last_o  = valid_q && !full_i && (beat_q == len_mask_i);
   assign beat_o  = beat_q;
   assign valid_o = valid_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         beat_q  <= '0;
         valid_q <= 1'b0;
      end else if (load_i) begin
         beat_q  <= '0;
         valid_q <= 1'b1;
      end else if (terminate_i) begin
         valid_q <= 1'b0;
      end else if (advance_i && valid_q) begin
         if (last_o) valid_q <= 1'b0;
         else        beat_q  <= beat_q + COL_W'(1);
      end
   end

   AST_BEAT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_q && !full_i) |-> ((beat_q & ~len_mask_i) == '0)); // R6

   AST_ADV_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!valid_q && !load_i) |=> !valid_q); // R11

endmodule

// File: rtl/bcg_col_map.sv
module bcg_col_map #(
   parameter int COL_W       = 8,
   parameter bit ILV_SUPPORT = 1'b1
) (
   input  logic [COL_W-1:0] start_i,
   input  logic [COL_W-1:0] beat_i,
   input  logic [COL_W-1:0] mask_i,
   input  logic             ilv_i,
   output logic [COL_W-1:0] col_o
);

   logic [COL_W-1:0] seq_col;
   logic [COL_W-1:0] sum;

   assign sum     = start_i + beat_i;
   assign seq_col = (start_i & ~mask_i) | (sum & mask_i);

   generate
      if (ILV_SUPPORT) begin : g_ilv
         logic [COL_W-1:0] ilv_col;
         assign ilv_col = start_i ^ (beat_i & mask_i);
         assign col_o   = ilv_i ? ilv_col : seq_col;
      end else begin : g_seq_only
         logic unused_ilv;
         assign unused_ilv = ilv_i;
         assign col_o      = seq_col;
      end
   endgenerate

endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
   import burst_col_pkg::*;
#(
   parameter int COL_W       = 8,
   parameter bit ILV_SUPPORT = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  load_i,
   input  logic [COL_W-1:0]      start_col_i,
   input  logic [LEN_CODE_W-1:0] blen_i,
   input  logic                  ilv_i,
   input  logic                  advance_i,
   input  logic                  terminate_i,
   output logic [COL_W-1:0]      col_o,
   output logic                  valid_o,
   output logic                  last_o
);

   initial begin
      if (COL_W < 3 || COL_W > 16)
         $error("burst_col_gen: COL_W must lie in 3..16");
   end

   logic [COL_W-1:0] dec_mask;
   logic             dec_full;
   logic [COL_W-1:0] start_q;
   logic [COL_W-1:0] mask_q;
   logic             full_q;
   logic             ilv_q;
   logic [COL_W-1:0] beat;

   bcg_len_decode #(.COL_W(COL_W)) u_dec (
      .code_i (blen_i),
      .mask_o (dec_mask),
      .full_o (dec_full)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_q <= '0;
         mask_q  <= '0;
         full_q  <= 1'b0;
         ilv_q   <= 1'b0;
      end else if (load_i) begin
         start_q <= start_col_i;
         mask_q  <= dec_mask;
         full_q  <= dec_full;
         ilv_q   <= ilv_i && !dec_full;
      end
   end

   bcg_beat_ctr #(.COL_W(COL_W)) u_ctr (
      .clk         (clk),
      .rst_n       (rst_n),
      .load_i      (load_i),
      .terminate_i (terminate_i),
      .advance_i   (advance_i),
      .full_i      (full_q),
      .len_mask_i  (mask_q),
      .beat_o      (beat),
      .valid_o     (valid_o),
      .last_o      (last_o)
   );

   bcg_col_map #(.COL_W(COL_W), .ILV_SUPPORT(ILV_SUPPORT)) u_map (
      .start_i (start_q),
      .beat_i  (beat),
      .mask_i  (mask_q),
      .ilv_i   (ilv_q),
      .col_o   (col_o)
   );

   AST_FIRST_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (valid_o && col_o == $past(start_col_i))); // R2

   AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> (((col_o ^ start_q) & ~mask_q) == '0)); // R4

   AST_ROW_NO_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      full_q |-> !last_o); // R7

   AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      (last_o && advance_i && !load_i) |=> !valid_o); // R6

   AST_TERMINATE: assert property (@(posedge clk) disable iff (!rst_n)
      (terminate_i && !load_i) |=> (!valid_o && !last_o)); // R8

   AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && !advance_i && !terminate_i && !load_i) |=> (valid_o && $stable(col_o))); // R10

endmodule

// File: tb/tb_burst_col_gen.sv
module tb_burst_col_gen;

   localparam int COL_W = 8;
   localparam int ROW   = 1 << COL_W;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             load_i = 1'b0;
   logic [COL_W-1:0] start_col_i = '0;
   logic [2:0]       blen_i = '0;
   logic             ilv_i = 1'b0;
   logic             advance_i = 1'b0;
   logic             terminate_i = 1'b0;
   logic [COL_W-1:0] col_o;
   logic             valid_o;
   logic             last_o;

   int n_run  = 0;
   int n_fail = 0;
   int cycles = 0;

   always #2.5 clk = ~clk;

   burst_col_gen #(.COL_W(COL_W)) dut (
      .clk(clk), .rst_n(rst_n), .load_i(load_i), .start_col_i(start_col_i),
      .blen_i(blen_i), .ilv_i(ilv_i), .advance_i(advance_i),
      .terminate_i(terminate_i), .col_o(col_o), .valid_o(valid_o), .last_o(last_o)
   );

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 100000) begin
         n_run  = n_run + 1;
         n_fail = n_fail + 1;
         $display("FAIL watchdog: run did not finish, actual %0d cycles expected fewer", cycles);
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      n_run = n_run + 1;
      if (act != exp) begin
         n_fail = n_fail + 1;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int beats_of(input int code);
      case (code)
         1: return 2;
         2: return 4;
         3: return 8;
         7: return ROW;
         default: return 1;
      endcase
   endfunction

   function automatic int exp_col(input int start, input int code, input int ilv, input int k);
      int n;
      n = beats_of(code);
      if (code == 7) return (start + k) % ROW;
      if (ilv != 0) return start ^ (k % n);
      return (start - (start % n)) + (((start % n) + k) % n);
   endfunction

   task automatic do_load(input int start, input int code, input int ilv);
      start_col_i = COL_W'(start);
      blen_i      = 3'(code);
      ilv_i       = ilv[0];
      load_i      = 1'b1;
      @(negedge clk);
      load_i      = 1'b0;
   endtask

   task automatic do_adv;
      advance_i = 1'b1;
      @(negedge clk);
      advance_i = 1'b0;
   endtask

   task automatic t_reset;
      chk("R1 valid", int'(valid_o), 0);
      chk("R1 last", int'(last_o), 0);
      chk("R1 col", int'(col_o), 0);
   endtask

   task automatic t_finite(input int start, input int code, input int ilv, input string req);
      int n;
      n = beats_of(code);
      do_load(start, code, ilv);
      chk("R2 first col", int'(col_o), start);
      for (int k = 0; k < n; k++) begin
         chk(req, int'(col_o), exp_col(start, code, ilv, k));
         chk("R6 last flag", int'(last_o), (k == n - 1) ? 1 : 0);
         chk("R6 valid during", int'(valid_o), 1);
         do_adv();
      end
      chk("R6 ended after last", int'(valid_o), 0);
      chk("R6 last low idle", int'(last_o), 0);
   endtask

   task automatic t_full_page;
      int start;
      start = 243;
      do_load(start, 7, 1);
      for (int k = 0; k < ROW + 3; k++) begin
         chk("R7 row col", int'(col_o), (start + k) % ROW);
         chk("R7 no last", int'(last_o), 0);
         chk("R7 still valid", int'(valid_o), 1);
         do_adv();
      end
      terminate_i = 1'b1;
      @(negedge clk);
      terminate_i = 1'b0;
      chk("R8 terminate row", int'(valid_o), 0);
   endtask

   task automatic t_terminate;
      do_load(8'h50, 3, 0);
      do_adv();
      do_adv();
      terminate_i = 1'b1;
      @(negedge clk);
      terminate_i = 1'b0;
      chk("R8 terminate valid", int'(valid_o), 0);
      chk("R8 terminate last", int'(last_o), 0);
      terminate_i = 1'b1;
      @(negedge clk);
      terminate_i = 1'b0;
      chk("R8 idle terminate", int'(valid_o), 0);
      chk("R8 idle col kept", int'(col_o), 8'h52);
   endtask

   task automatic t_restart;
      do_load(8'h11, 2, 1);
      do_adv();
      chk("R5 beat1", int'(col_o), 8'h10);
      do_load(8'hC6, 3, 0);
      chk("R9 restart col", int'(col_o), 8'hC6);
      do_adv();
      chk("R9 restart beat1", int'(col_o), 8'hC7);
      do_adv();
      chk("R4 wrap in block", int'(col_o), 8'hC0);
      start_col_i = 8'h3D; blen_i = 3'd1; ilv_i = 1'b0;
      load_i = 1'b1; terminate_i = 1'b1; advance_i = 1'b1;
      @(negedge clk);
      load_i = 1'b0; terminate_i = 1'b0; advance_i = 1'b0;
      chk("R9 load wins valid", int'(valid_o), 1);
      chk("R9 load wins col", int'(col_o), 8'h3D);
      do_adv();
      chk("R9 second beat", int'(col_o), 8'h3C);
      chk("R9 second last", int'(last_o), 1);
      do_adv();
      chk("R9 done", int'(valid_o), 0);
   endtask

   task automatic t_hold_and_idle;
      do_load(8'h84, 3, 1);
      do_adv();
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         chk("R10 hold col", int'(col_o), 8'h85);
         chk("R10 hold valid", int'(valid_o), 1);
      end
      terminate_i = 1'b1;
      @(negedge clk);
      terminate_i = 1'b0;
      do_adv();
      do_adv();
      chk("R11 idle advance valid", int'(valid_o), 0);
      chk("R11 idle advance col", int'(col_o), 8'h85);
   endtask

   task automatic t_reserved;
      for (int c = 4; c < 7; c++) begin
         do_load(8'hA7, c, 0);
         chk("R3 reserved one beat last", int'(last_o), 1);
         chk("R3 reserved col", int'(col_o), 8'hA7);
         do_adv();
         chk("R3 reserved ended", int'(valid_o), 0);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_finite(8'h37, 0, 0, "R3 len1");
      t_finite(8'h37, 1, 0, "R4 seq len2");
      t_finite(8'h37, 2, 0, "R4 seq len4");
      t_finite(8'h35, 3, 0, "R4 seq len8");
      t_finite(8'hFE, 3, 0, "R4 seq len8 top");
      t_finite(8'h37, 1, 1, "R5 ilv len2");
      t_finite(8'h36, 2, 1, "R5 ilv len4");
      t_finite(8'h35, 3, 1, "R5 ilv len8");
      t_finite(8'h02, 3, 1, "R5 ilv len8 low");
      t_reserved();
      t_full_page();
      t_terminate();
      t_restart();
      t_hold_and_idle();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule